// File: doc/BRIEF.md
# Card Host Interrupt Status Unit

This block gathers the event and error pulses of a removable flash-card host controller into one 32-bit interrupt status register. The command engine, data FIFO, DMA engine and error detectors each raise a one-cycle pulse on their own bit of an event vector. The card-present line is synchronized inside the block and turned into insertion and removal events. Two masks shape the result. The status-enable mask decides which events are allowed to latch. The signal-enable mask decides which latched bits drive the single level interrupt output. Software clears status bits by writing ones to them.

A summary error bit (bit 15) collects the four error causes (bits 16 to 19). It follows those causes by one cycle and can only be cleared once they have all been cleared. A one-cycle reset-complete pulse loads both masks with the default set of enabled bits. The FIFO-ready bits are not in that default set, so software turns them on for each transfer that needs them.

Card detection uses a two-state machine. In the state `CD_ABSENT`, a synchronized present level takes the transition `CD_ABSENT -> CD_PRESENT` and emits an insertion pulse in that cycle. In the state `CD_PRESENT`, a synchronized absent level takes the transition `CD_PRESENT -> CD_ABSENT` and emits a removal pulse. Otherwise the machine stays in its state and emits nothing.

Top module: `card_irq_status`

## Requirements
- R1: After reset, the status register, the status-enable mask and the signal-enable mask all read zero, and `irq_o` is low.
- R2: A pulse on `evt_i` bit 0 (end of command), 1 (end of transfer), 2 (DMA boundary), 6 (FIFO read-ready), 7 (FIFO write-ready), 16 (handshake timeout), 17 (timer timeout), 18 (CRC error) or 19 (command-code error) sets the same status bit on the next clock edge, but only when that bit of the status-enable mask is one. Bits 3, 4 and 15 of `evt_i`, and every other bit, are ignored.
- R3: A write to the status register clears each bit written as one and leaves each bit written as zero unchanged.
- R4: When a bit's set condition and a clear of that bit by a write fall in the same cycle, the bit is left set.
- R5: `irq_o` is high exactly while some status bit is one and its signal-enable bit is also one. The signal-enable mask has no effect on latching.
- R6: Status bit 15 is set one cycle after any of status bits 16 to 19 is one, if status-enable bit 15 is one. A write of one to bit 15 leaves it set while any of bits 16 to 19 is still one.
- R7: A pulse on `reset_done_i` loads both masks with 0x000F801F on the next edge. This pulse takes priority over a register write in the same cycle.
- R8: Only the bits in 0x000F80DF exist in the status register and in both masks. Writes to other bits are ignored, and those bits read as zero.
- R9: `card_present_i` passes through a synchronizer. A rising level sets status bit 3 and a falling level sets status bit 4, each once per change and within four clock edges.
- R10: `reg_addr_i` selects 0 for status, 1 for status-enable, 2 for signal-enable, and 3 for a read-only zero. The read data follows the address in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_addr_i | input | 2 | Register select for read and write |
| reg_wr_i | input | 1 | Write strobe |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for the selected register |
| evt_i | input | 32 | One-cycle event and error pulses |
| card_present_i | input | 1 | Asynchronous card-present level |
| reset_done_i | input | 1 | Pulse that loads the default masks |
| irq_o | output | 1 | Level interrupt output |

## Verification
The assertions assume that event inputs are pulses sampled only at clock edges, and that the write strobe and address settle well before each edge. The bench drives every input on the falling edge so that this holds. For the card-present line, they assume each level lasts longer than the synchronizer depth plus one cycle. The bench therefore holds each level for several cycles. They also assume `reset_done_i` is a single-cycle pulse, and the bench raises it for exactly one cycle.

// File: rtl/cis_pkg.sv
package cis_pkg;
    localparam int          DW          = 32;
    localparam logic [31:0] IMPL_MASK   = 32'h000F_80DF;
    localparam logic [31:0] DEF_EN_MASK = 32'h000F_801F;
    localparam logic [31:0] EXT_EV_MASK = 32'h000F_00C7;
    localparam int          B_MEDIA_IN  = 3;
    localparam int          B_MEDIA_OUT = 4;
    localparam int          B_ANY_ERR   = 15;
    localparam int          B_ERR_LO    = 16;
    localparam int          B_ERR_HI    = 19;

    typedef enum logic [1:0] {
        RA_STATUS = 2'd0,
        RA_STEN   = 2'd1,
        RA_SIGEN  = 2'd2,
        RA_NONE   = 2'd3
    } reg_addr_e;

    typedef enum logic {
        CD_ABSENT  = 1'b0,
        CD_PRESENT = 1'b1
    } cd_state_e;
endpackage

// File: rtl/cis_card_detect.sv
module cis_card_detect
    import cis_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic card_i,
    output logic ins_o,
    output logic rem_o
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   seen;
    cd_state_e              state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], card_i};
    end
    assign seen = sync_q[SYNC_STAGES-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CD_ABSENT;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        ins_o   = 1'b0;
        rem_o   = 1'b0;
        unique case (state_q)
            CD_ABSENT:  if (seen)  begin state_d = CD_PRESENT; ins_o = 1'b1; end
            CD_PRESENT: if (!seen) begin state_d = CD_ABSENT;  rem_o = 1'b1; end
        endcase
    end

    assert_ins_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ins_o |=> !ins_o);
    assert_rem_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rem_o |=> !rem_o);
endmodule

// File: rtl/cis_status_bank.sv
module cis_status_bank
    import cis_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] ev_i,
    input  logic [DW-1:0] st_en_i,
    input  logic [DW-1:0] clr_i,
    output logic [DW-1:0] status_o
);
    logic [DW-1:0] status_q, set_vec, sum_vec;
    logic          err_any;

    assign err_any = |status_q[B_ERR_HI:B_ERR_LO];

    always_comb begin
        sum_vec            = '0;
        sum_vec[B_ANY_ERR] = err_any;
    end

    assign set_vec = (ev_i | sum_vec) & st_en_i & IMPL_MASK;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) status_q <= '0;
        else        status_q <= ((status_q & ~clr_i) | set_vec) & IMPL_MASK;
    end

    assign status_o = status_q;

    assert_w1c_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i != '0) |=> ((status_q & $past(clr_i & ~set_vec)) == '0));
    assert_set_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (set_vec != '0) |=> ((status_q & $past(set_vec)) == $past(set_vec)));
    assert_no_spurious_R2: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((status_q & ~$past(status_q) & ~$past(set_vec)) == '0));
    assert_err_summary_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (err_any && st_en_i[B_ANY_ERR]) |=> status_q[B_ANY_ERR]);
endmodule

// File: rtl/cis_enable_regs.sv
module cis_enable_regs
    import cis_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_def_i,
    input  logic          wr_sten_i,
    input  logic          wr_sigen_i,
    input  logic [DW-1:0] wdata_i,
    output logic [DW-1:0] sten_o,
    output logic [DW-1:0] sigen_o
);
    logic [DW-1:0] sten_q, sigen_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sten_q  <= '0;
            sigen_q <= '0;
        end else if (load_def_i) begin
            sten_q  <= DEF_EN_MASK;
            sigen_q <= DEF_EN_MASK;
        end else begin
            if (wr_sten_i)  sten_q  <= wdata_i & IMPL_MASK;
            if (wr_sigen_i) sigen_q <= wdata_i & IMPL_MASK;
        end
    end

    assign sten_o  = sten_q;
    assign sigen_o = sigen_q;

    assert_load_default_R7: assert property (@(posedge clk) disable iff (!rst_n)
        load_def_i |=> (sten_q == DEF_EN_MASK && sigen_q == DEF_EN_MASK));
    assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_def_i && !wr_sten_i) |=> $stable(sten_q));
endmodule

// File: rtl/card_irq_status.sv
module card_irq_status
    import cis_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    reg_addr_i,
    input  logic          reg_wr_i,
    input  logic [DW-1:0] reg_wdata_i,
    output logic [DW-1:0] reg_rdata_o,
    input  logic [DW-1:0] evt_i,
    input  logic          card_present_i,
    input  logic          reset_done_i,
    output logic          irq_o
);
    reg_addr_e     ra;
    logic          ins, rem;
    logic [DW-1:0] ev_all, clr_vec, status, sten, sigen;

    assign ra = reg_addr_e'(reg_addr_i);

    cis_card_detect #(.SYNC_STAGES(SYNC_STAGES)) u_cd (
        .clk(clk), .rst_n(rst_n), .card_i(card_present_i),
        .ins_o(ins), .rem_o(rem)
    );

    always_comb begin
        ev_all              = evt_i & EXT_EV_MASK;
        ev_all[B_MEDIA_IN]  = ins;
        ev_all[B_MEDIA_OUT] = rem;
    end

    assign clr_vec = (reg_wr_i && ra == RA_STATUS) ? reg_wdata_i : '0;

    cis_status_bank u_bank (
        .clk(clk), .rst_n(rst_n), .ev_i(ev_all), .st_en_i(sten),
        .clr_i(clr_vec), .status_o(status)
    );

    cis_enable_regs u_en (
        .clk(clk), .rst_n(rst_n), .load_def_i(reset_done_i),
        .wr_sten_i(reg_wr_i && ra == RA_STEN),
        .wr_sigen_i(reg_wr_i && ra == RA_SIGEN),
        .wdata_i(reg_wdata_i), .sten_o(sten), .sigen_o(sigen)
    );

    always_comb begin
        unique case (ra)
            RA_STATUS: reg_rdata_o = status;
            RA_STEN:   reg_rdata_o = sten;
            RA_SIGEN:  reg_rdata_o = sigen;
            RA_NONE:   reg_rdata_o = '0;
        endcase
    end

    assign irq_o = |(status & sigen);

    assert_irq_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (sigen == '0) |-> !irq_o);
    assert_unimpl_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((status | sten | sigen) & ~IMPL_MASK) == '0);
endmodule

// File: tb/sim_card_irq_status.sv
module sim_card_irq_status;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  addr = 2'd0;
    logic        wr = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [31:0] evt = '0;
    logic        card = 1'b0;
    logic        rdone = 1'b0;
    logic        irq;
    int          n_chk = 0;
    int          n_fail = 0;
    bit          done = 1'b0;

    localparam logic [31:0] IMPL = 32'h000F80DF;
    localparam int NV = 7;
    localparam logic [31:0] TV_EV   [0:NV-1] = '{32'h1, 32'h2, 32'hC4, 32'h18, 32'h00F0_8000, 32'h0001_0000, 32'h0008_0000};
    localparam logic [31:0] TV_STEN [0:NV-1] = '{IMPL, 32'h1, IMPL, IMPL, IMPL, IMPL, 32'h000F_8000};
    localparam logic [31:0] TV_SIG  [0:NV-1] = '{32'h1, IMPL, 32'h40, IMPL, IMPL, 32'h0, 32'h0008_0000};
    localparam logic [31:0] TV_STAT [0:NV-1] = '{32'h1, 32'h0, 32'hC4, 32'h0, 32'h0, 32'h0001_0000, 32'h0008_0000};
    localparam logic        TV_IRQ  [0:NV-1] = '{1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1};

    card_irq_status u0 (
        .clk(clk), .rst_n(rst_n), .reg_addr_i(addr), .reg_wr_i(wr),
        .reg_wdata_i(wdata), .reg_rdata_o(rdata), .evt_i(evt),
        .card_present_i(card), .reset_done_i(rdone), .irq_o(irq)
    );

    always #10 clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic wr_reg(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk); addr = a; wdata = d; wr = 1'b1;
        @(negedge clk); wr = 1'b0; wdata = '0;
    endtask

    task automatic rd_reg(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk); addr = a; #1 d = rdata;
    endtask

    task automatic pulse(input logic [31:0] e);
        @(negedge clk); evt = e;
        @(negedge clk); evt = '0;
    endtask

    task automatic quiesce();
        wr_reg(2'd1, 32'h0);
        wr_reg(2'd0, 32'hFFFF_FFFF);
        wr_reg(2'd0, 32'hFFFF_FFFF);
    endtask

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        rd_reg(2'd0, v); chk("R1 status", v, 32'h0);
        rd_reg(2'd1, v); chk("R1 sten", v, 32'h0);
        rd_reg(2'd2, v); chk("R1 sigen", v, 32'h0);
        chk("R1 irq", {31'b0, irq}, 32'h0);

        // table walk: R2 R5 R8
        for (int i = 0; i < NV; i++) begin
            quiesce();
            wr_reg(2'd2, TV_SIG[i]);
            wr_reg(2'd1, TV_STEN[i]);
            pulse(TV_EV[i]);
            addr = 2'd0; #1;
            chk($sformatf("R2 vector %0d status", i), rdata, TV_STAT[i]);
            chk($sformatf("R5 vector %0d irq", i), {31'b0, irq}, {31'b0, TV_IRQ[i]});
        end

        // R7 default load
        quiesce();
        @(negedge clk); rdone = 1'b1;
        @(negedge clk); rdone = 1'b0;
        rd_reg(2'd1, v); chk("R7 sten default", v, 32'h000F801F);
        rd_reg(2'd2, v); chk("R7 sigen default", v, 32'h000F801F);
        // R7 priority over a write in the same cycle
        @(negedge clk); addr = 2'd1; wdata = 32'h1; wr = 1'b1; rdone = 1'b1;
        @(negedge clk); wr = 1'b0; rdone = 1'b0;
        rd_reg(2'd1, v); chk("R7 load beats write", v, 32'h000F801F);

        // R8 unimplemented bits, R10 address 3
        wr_reg(2'd1, 32'hFFFF_FFFF);
        rd_reg(2'd1, v); chk("R8 sten mask", v, IMPL);
        rd_reg(2'd3, v); chk("R10 addr3 zero", v, 32'h0);

        // R3 partial clear and zero write
        quiesce();
        wr_reg(2'd1, IMPL);
        pulse(32'h3);
        wr_reg(2'd0, 32'h1);
        rd_reg(2'd0, v); chk("R3 clear bit0 only", v, 32'h2);
        wr_reg(2'd0, 32'h0);
        rd_reg(2'd0, v); chk("R3 zero write keeps", v, 32'h2);

        // R4 collision: event and clear same cycle
        pulse(32'h1);
        @(negedge clk); addr = 2'd0; wdata = 32'h1; wr = 1'b1; evt = 32'h1;
        @(negedge clk); wr = 1'b0; evt = '0; #1;
        chk("R4 set wins", rdata & 32'h1, 32'h1);
        wr_reg(2'd0, 32'h1);
        rd_reg(2'd0, v); chk("R3 then cleared", v & 32'h1, 32'h0);

        // R6 summary error bit
        quiesce();
        wr_reg(2'd1, IMPL);
        pulse(32'h0002_0000);
        addr = 2'd0; #1; chk("R6 cause only", rdata, 32'h0002_0000);
        @(negedge clk); #1; chk("R6 summary follows", rdata, 32'h0002_8000);
        wr_reg(2'd0, 32'h0000_8000);
        rd_reg(2'd0, v); chk("R6 summary held by cause", v, 32'h0002_8000);
        wr_reg(2'd0, 32'h0002_0000);
        rd_reg(2'd0, v); chk("R6 cause cleared", v, 32'h0000_8000);
        wr_reg(2'd0, 32'h0000_8000);
        rd_reg(2'd0, v); chk("R6 summary cleared", v, 32'h0);

        // R9 card detect
        @(negedge clk); card = 1'b1;
        repeat (4) @(negedge clk);
        addr = 2'd0; #1; chk("R9 insertion", rdata, 32'h8);
        wr_reg(2'd0, 32'h8);
        repeat (4) @(negedge clk);
        rd_reg(2'd0, v); chk("R9 insert once", v, 32'h0);
        card = 1'b0;
        repeat (4) @(negedge clk);
        addr = 2'd0; #1; chk("R9 removal", rdata, 32'h10);

        done = 1'b1;
    end

    initial begin
        fork
            begin wait (done); end
            begin
                repeat (100000) @(posedge clk);
                n_chk++; n_fail++;
                $display("FAIL watchdog: got timeout expected completion");
            end
        join_any
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule